// File: doc/BRIEF.md
# Interrupt Set-Enable Register Bank

This block holds the per-interrupt forwarding enables of an interrupt distributor. Each stored bit decides whether one interrupt may be forwarded to the processor interfaces. Software reaches the bits through two word-wide windows. In the set window, every data bit written as 1 turns on the matching enable. In the clear window, every data bit written as 1 turns it off. A read in either window returns the current enable state. Written zeros never change anything.

Register 0 covers the sixteen software-generated and sixteen private interrupts, and each connected processor has its own copy of it. Registers 1 and up are shared by all processors. A register access is a single-cycle strobe. It carries a byte address, write data, a non-secure flag and the index of the requesting processor. Read data is returned combinationally in the same cycle. A write takes effect at the next rising clock edge.

Bits that a given access may not touch read as zero and ignore writes. Such bits are unimplemented interrupts and, while the security-disable input is low, secure-group interrupts seen from a non-secure access. Holding the main enables is the whole job of this block. Priority, pending state and delivery to the processors belong to other blocks.

Top module: `irqen_bank`

## Requirements
- R1: After reset every enable output bit is 0, except that with `SGI_FIXED`=1 bits 0..15 of each processor's register 0 read as 1.
- R2: A write to byte address 0x100 + 4*n sets enable bit x of register n (interrupt 32n + x) for each data bit x that is 1. Data bits that are 0 leave their enables unchanged.
- R3: A write to byte address 0x180 + 4*n clears each enable bit whose data bit is 1. A read at either 0x100 + 4*n or 0x180 + 4*n returns the current enable state of register n, subject to R5 to R9.
- R4: Register 0 is kept separately for each processor index below `NUM_PROCS`. An access selects the copy named by `regProc`. Output bits 32p..32p+31 of `privEnable` hold processor p's copy.
- R5: An access to register 0 with `regProc` >= `NUM_PROCS` (`NUM_PROCS` is at most 8) reads 0 and changes no state.
- R6: Enable bits of interrupt numbers >= `IMPL_INTS` always read 0 and ignore writes, and their outputs stay 0.
- R7: With `secDisable`=0, a `regNonSecure`=1 access reads 0 from, and cannot change, any bit whose group input is 0. A group input of 1 marks a non-secure group interrupt. Secure accesses, and every access while `secDisable`=1, are not masked this way.
- R8: With `SGI_FIXED`=1, bits 0..15 of every register 0 copy stay 1 through any set or clear write. With `SGI_FIXED`=0 these bits behave like the others.
- R9: Addresses with index n >= `LINE_COUNT`+1, addresses outside 0x100..0x1FF, and addresses whose low two bits are not 00 read 0 and change no state.
- R10: `regRdata` carries read data only while `regValid`=1 and `regWrite`=0, and is 0 otherwise. Read data is valid in the same cycle. Writes take effect at the next rising edge.
- R11: `sharedEnable` bits 32(n-1)..32(n-1)+31 always equal the stored state of register n, for n >= 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| secDisable | input | 1 | 1 turns off the security masking of non-secure accesses |
| regValid | input | 1 | Register access strobe for this cycle |
| regWrite | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 12 | Byte address within the distributor frame |
| regProc | input | 4 | Index of the requesting processor |
| regNonSecure | input | 1 | 1 marks the access as non-secure |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| grpNsPriv | input | NUM_PROCS*32 | Per-processor group flags for register 0, 1 = non-secure group |
| grpNsShared | input | LINE_COUNT*32 | Group flags for registers 1 and up, 1 = non-secure group |
| privEnable | output | NUM_PROCS*32 | Enable state of each processor's register 0 |
| sharedEnable | output | LINE_COUNT*32 | Enable state of registers 1 and up |

## Verification
The assertions check the following on every cycle. A set-window write never drops a bit, and a clear-window write never raises one. Cycles without a write leave every enable unchanged. Unimplemented bits stay 0. Fixed software-generated bits stay 1. Register 0 accesses from an out-of-range processor return zero and leave the state alone. Whether the right bits move, which depends jointly on the group flags, the security inputs, the processor copy and the register index, can only be shown by the bench. Its sweep compares every write and read-back against an arithmetic model.

// File: rtl/irqen_pkg.sv
package irqen_pkg;
  localparam int IDX_W  = 5;
  localparam int PROC_W = 3;

  typedef struct packed {
    logic              setStb;
    logic              clrStb;
    logic              rdStb;
    logic              privSel;
    logic [IDX_W-1:0]  regIdx;
    logic [PROC_W-1:0] procIdx;
  } enCtrlT;
endpackage

// File: rtl/irqen_ctrl.sv
module irqen_ctrl
  import irqen_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int LINE_COUNT = 2
) (
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [11:0] regAddr,
  input  logic [3:0]  regProc,
  output enCtrlT      ctrl
);
  localparam int NUM_REGS = LINE_COUNT + 1;
  localparam logic [IDX_W:0] REGS_LIM  = (IDX_W+1)'(NUM_REGS);
  localparam logic [4:0]     PROCS_LIM = 5'(NUM_PROCS);

  logic inSet, inClr, aligned, idxOk, procOk, isPriv, hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    inSet   = (regAddr[11:7] == 5'd2);
    inClr   = (regAddr[11:7] == 5'd3);
    aligned = (regAddr[1:0] == 2'b00);
    idx     = regAddr[6:2];
    idxOk   = ({1'b0, idx} < REGS_LIM);
    isPriv  = (idx == '0);
    procOk  = ({1'b0, regProc} < PROCS_LIM);
    hit     = (inSet || inClr) && aligned && idxOk && (!isPriv || procOk);

    ctrl.setStb  = regValid && regWrite && hit && inSet;
    ctrl.clrStb  = regValid && regWrite && hit && inClr;
    ctrl.rdStb   = regValid && !regWrite && hit;
    ctrl.privSel = isPriv;
    ctrl.regIdx  = idx;
    ctrl.procIdx = regProc[PROC_W-1:0];
  end
endmodule

// File: rtl/irqen_dp.sv
module irqen_dp
  import irqen_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int LINE_COUNT = 2,
  parameter int IMPL_INTS  = 80,
  parameter bit SGI_FIXED  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  enCtrlT                     ctrl,
  input  logic [31:0]                wrData,
  input  logic                       nonSecure,
  input  logic                       secDisable,
  input  logic [NUM_PROCS*32-1:0]    grpNsPriv,
  input  logic [LINE_COUNT*32-1:0]   grpNsShared,
  output logic [31:0]                rdData,
  output logic [NUM_PROCS*32-1:0]    privEnable,
  output logic [LINE_COUNT*32-1:0]   sharedEnable
);
  localparam logic [31:0] SGI_LOCK = SGI_FIXED ? 32'h0000_FFFF : 32'h0;

  function automatic logic [31:0] implOf(int n);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((32 * n + b) < IMPL_INTS);
    return m;
  endfunction

  logic [31:0] grpSel, curState, implSel, accMask, wrBits;

  always_comb begin
    grpSel   = '0;
    curState = '0;
    implSel  = '0;
    if (ctrl.privSel) begin
      implSel = implOf(0);
      for (int p = 0; p < NUM_PROCS; p++) begin
        if (ctrl.procIdx == PROC_W'(p)) begin
          grpSel   = grpNsPriv[p*32 +: 32];
          curState = privEnable[p*32 +: 32];
        end
      end
    end else begin
      for (int n = 1; n <= LINE_COUNT; n++) begin
        if (ctrl.regIdx == IDX_W'(n)) begin
          grpSel   = grpNsShared[(n-1)*32 +: 32];
          curState = sharedEnable[(n-1)*32 +: 32];
          implSel  = implOf(n);
        end
      end
    end
    accMask = implSel & ((secDisable || !nonSecure) ? 32'hFFFF_FFFF : grpSel);
    rdData  = ctrl.rdStb ? (curState & accMask) : 32'h0;
    wrBits  = wrData & accMask & ~(ctrl.privSel ? SGI_LOCK : 32'h0);
  end

  genvar gp, gn;
  generate
    for (gp = 0; gp < NUM_PROCS; gp++) begin : g_priv
      logic [31:0] q;
      logic        sel;
      assign sel = ctrl.privSel && (ctrl.procIdx == PROC_W'(gp));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    q <= SGI_LOCK;
        else if (sel && ctrl.setStb)  q <= q | wrBits;
        else if (sel && ctrl.clrStb)  q <= q & ~wrBits;
      end
      assign privEnable[gp*32 +: 32] = q;
    end

    for (gn = 1; gn <= LINE_COUNT; gn++) begin : g_shared
      logic [31:0] q;
      logic        sel;
      assign sel = !ctrl.privSel && (ctrl.regIdx == IDX_W'(gn));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    q <= '0;
        else if (sel && ctrl.setStb)  q <= q | wrBits;
        else if (sel && ctrl.clrStb)  q <= q & ~wrBits;
      end
      assign sharedEnable[(gn-1)*32 +: 32] = q;
    end
  endgenerate
endmodule

// File: rtl/irqen_bank.sv
module irqen_bank
  import irqen_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int LINE_COUNT = 2,
  parameter int IMPL_INTS  = 80,
  parameter bit SGI_FIXED  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     secDisable,
  input  logic                     regValid,
  input  logic                     regWrite,
  input  logic [11:0]              regAddr,
  input  logic [3:0]               regProc,
  input  logic                     regNonSecure,
  input  logic [31:0]              regWdata,
  output logic [31:0]              regRdata,
  input  logic [NUM_PROCS*32-1:0]  grpNsPriv,
  input  logic [LINE_COUNT*32-1:0] grpNsShared,
  output logic [NUM_PROCS*32-1:0]  privEnable,
  output logic [LINE_COUNT*32-1:0] sharedEnable
);
  enCtrlT ctrl;

  irqen_ctrl #(
    .NUM_PROCS  (NUM_PROCS),
    .LINE_COUNT (LINE_COUNT)
  ) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regProc  (regProc),
    .ctrl     (ctrl)
  );

  irqen_dp #(
    .NUM_PROCS  (NUM_PROCS),
    .LINE_COUNT (LINE_COUNT),
    .IMPL_INTS  (IMPL_INTS),
    .SGI_FIXED  (SGI_FIXED)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .wrData       (regWdata),
    .nonSecure    (regNonSecure),
    .secDisable   (secDisable),
    .grpNsPriv    (grpNsPriv),
    .grpNsShared  (grpNsShared),
    .rdData       (regRdata),
    .privEnable   (privEnable),
    .sharedEnable (sharedEnable)
  );
endmodule

// File: rtl/irqen_bank_chk.sv
module irqen_bank_chk #(
  parameter int NUM_PROCS  = 4,
  parameter int LINE_COUNT = 2,
  parameter int IMPL_INTS  = 80,
  parameter bit SGI_FIXED  = 1'b0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regValid,
  input logic                     regWrite,
  input logic [11:0]              regAddr,
  input logic [3:0]               regProc,
  input logic [31:0]              regRdata,
  input logic [NUM_PROCS*32-1:0]  privEnable,
  input logic [LINE_COUNT*32-1:0] sharedEnable
);
  logic [LINE_COUNT*32-1:0] implShared;
  logic setWin, clrWin, badProcAcc;

  always_comb begin
    for (int i = 0; i < LINE_COUNT*32; i++) implShared[i] = ((i + 32) < IMPL_INTS);
    setWin     = regValid && regWrite && (regAddr[11:7] == 5'd2);
    clrWin     = regValid && regWrite && (regAddr[11:7] == 5'd3);
    badProcAcc = regValid && (regAddr[11:8] == 4'h1) && (regAddr[6:0] == 7'd0)
                 && ({1'b0, regProc} >= 5'(NUM_PROCS));
  end

  p_set_no_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    setWin |=> (((privEnable & $past(privEnable)) == $past(privEnable)) &&
                ((sharedEnable & $past(sharedEnable)) == $past(sharedEnable))));

  p_clr_no_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    clrWin |=> (((privEnable | $past(privEnable)) == $past(privEnable)) &&
                ((sharedEnable | $past(sharedEnable)) == $past(sharedEnable))));

  p_bad_proc_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    badProcAcc |-> (regRdata == 32'h0));

  p_bad_proc_wr_r5: assert property (@(posedge clk) disable iff (!rstN)
    badProcAcc |=> $stable(privEnable));

  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sharedEnable & ~implShared) == '0);

  p_idle_rd_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |-> (regRdata == 32'h0));

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regWrite) |=> ($stable(privEnable) && $stable(sharedEnable)));

  genvar gp;
  generate
    if (SGI_FIXED) begin : g_sgi
      for (gp = 0; gp < NUM_PROCS; gp++) begin : g_p
        p_sgi_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
          privEnable[gp*32 +: 16] == 16'hFFFF);
      end
    end
  endgenerate
endmodule

bind irqen_bank irqen_bank_chk #(
  .NUM_PROCS  (NUM_PROCS),
  .LINE_COUNT (LINE_COUNT),
  .IMPL_INTS  (IMPL_INTS),
  .SGI_FIXED  (SGI_FIXED)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regValid     (regValid),
  .regWrite     (regWrite),
  .regAddr      (regAddr),
  .regProc      (regProc),
  .regRdata     (regRdata),
  .privEnable   (privEnable),
  .sharedEnable (sharedEnable)
);

// File: tb/irqen_bank_tb.sv
`timescale 1ns/1ps
module irqen_bank_tb;
  localparam int NP   = 4;
  localparam int LC   = 2;
  localparam int NR   = LC + 1;
  localparam int IMPL = 80;
  localparam logic [NP*32-1:0] GRP_PRIV =
    {32'h6B2D_F01E, 32'h0F0F_F0F0, 32'hA5A5_5A5A, 32'h3C96_C369};
  localparam logic [LC*32-1:0] GRP_SHARED = {32'h0FF0_F00F, 32'h5555_AAAA};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secDisable = 1'b0, regValid = 1'b0, regWrite = 1'b0, regNonSecure = 1'b0;
  logic [11:0] regAddr = '0;
  logic [3:0]  regProc = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdMain, rdSgi;
  logic [NP*32-1:0] privMain, privSgi;
  logic [LC*32-1:0] sharedMain, sharedSgi;

  always #2.5 clk = ~clk;

  irqen_bank #(.NUM_PROCS(NP), .LINE_COUNT(LC), .IMPL_INTS(IMPL), .SGI_FIXED(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .secDisable(secDisable), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regProc(regProc), .regNonSecure(regNonSecure), .regWdata(regWdata),
    .regRdata(rdMain), .grpNsPriv(GRP_PRIV), .grpNsShared(GRP_SHARED),
    .privEnable(privMain), .sharedEnable(sharedMain));

  irqen_bank #(.NUM_PROCS(NP), .LINE_COUNT(LC), .IMPL_INTS(IMPL), .SGI_FIXED(1'b1)) u_dutSgi (
    .clk(clk), .rstN(rstN), .secDisable(secDisable), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regProc(regProc), .regNonSecure(regNonSecure), .regWdata(regWdata),
    .regRdata(rdSgi), .grpNsPriv(GRP_PRIV), .grpNsShared(GRP_SHARED),
    .privEnable(privSgi), .sharedEnable(sharedSgi));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] mPriv [NP];
  logic [31:0] mShared [LC];

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] implOf(int n);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((32 * n + b) < IMPL);
    return m;
  endfunction

  function automatic bit validTgt(int idx, int proc);
    return (idx < NR) && (idx != 0 || proc < NP);
  endfunction

  function automatic logic [31:0] maskOf(int idx, int proc, bit ns, bit ds);
    logic [31:0] g;
    g = (idx == 0) ? GRP_PRIV[proc*32 +: 32] : GRP_SHARED[(idx-1)*32 +: 32];
    return implOf(idx) & ((ds || !ns) ? 32'hFFFF_FFFF : g);
  endfunction

  function automatic logic [31:0] expRead(int idx, int proc, bit ns, bit ds, bit fixed);
    logic [31:0] s;
    if (!validTgt(idx, proc)) return 32'h0;
    s = (idx == 0) ? mPriv[proc] : mShared[idx-1];
    if (fixed && idx == 0) s = s | 32'h0000_FFFF;
    return s & maskOf(idx, proc, ns, ds);
  endfunction

  function automatic string tagOf(int idx, int proc, bit ns, bit ds, bit clr);
    if (idx >= NR) return "R9";
    if (idx == 0 && proc >= NP) return "R5";
    if (ns && !ds) return "R7";
    if (idx == 2) return "R6";
    if (idx == 0) return "R4";
    return clr ? "R3" : "R2";
  endfunction

  task automatic checkOutputs(input string tag);
    logic [NP*32-1:0] ep, es;
    logic [LC*32-1:0] eh;
    for (int p = 0; p < NP; p++) begin
      ep[p*32 +: 32] = mPriv[p];
      es[p*32 +: 32] = mPriv[p] | 32'h0000_FFFF;
    end
    for (int n = 0; n < LC; n++) eh[n*32 +: 32] = mShared[n];
    check({tag, " R11 priv"}, 128'(privMain), 128'(ep));
    check({tag, " R11 shared"}, 128'(sharedMain), 128'(eh));
    check({tag, " R8 fixed-sgi priv"}, 128'(privSgi), 128'(es));
    check({tag, " R8 fixed-sgi shared"}, 128'(sharedSgi), 128'(eh));
  endtask

  task automatic doWrite(input logic [11:0] addr, input int proc, input bit ns, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = addr; regProc = 4'(proc);
    regNonSecure = ns; regWdata = d;
    #1;
    check("R10 rdata zero during write", 128'(rdMain), 128'(0));
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] addr, input int proc, input bit ns, input logic [31:0] expM,
                        input logic [31:0] expS, input string tag);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = addr; regProc = 4'(proc); regNonSecure = ns;
    #1;
    check({tag, " read"}, 128'(rdMain), 128'(expM));
    check({tag, " R8 fixed-sgi read"}, 128'(rdSgi), 128'(expS));
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic modelWrite(input int idx, input int proc, input bit ns, input bit ds,
                            input bit clr, input logic [31:0] d);
    logic [31:0] bits;
    if (!validTgt(idx, proc)) return;
    bits = d & maskOf(idx, proc, ns, ds);
    if (idx == 0) mPriv[proc] = clr ? (mPriv[proc] & ~bits) : (mPriv[proc] | bits);
    else mShared[idx-1] = clr ? (mShared[idx-1] & ~bits) : (mShared[idx-1] | bits);
  endtask

  initial begin
    int cnt;
    logic [31:0] d;
    for (int p = 0; p < NP; p++) mPriv[p] = '0;
    for (int n = 0; n < LC; n++) mShared[n] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOutputs("R1 reset");
    check("R10 idle rdata", 128'(rdMain), 128'(0));

    cnt = 0;
    for (int ds = 0; ds < 2; ds++) begin
      for (int ns = 0; ns < 2; ns++) begin
        for (int proc = 0; proc < 10; proc++) begin
          for (int win = 0; win < 2; win++) begin
            for (int idx = 0; idx < 4; idx++) begin
              string tg;
              logic [11:0] a, alt;
              cnt++;
              secDisable = ds[0];
              d = (32'(cnt) * 32'h9E37_79B9) ^ (32'(cnt) << 7);
              if (win == 1) d = d & (32'(cnt) * 32'h2545_F491);
              tg = tagOf(idx, proc, ns[0], ds[0], win[0]);
              a   = 12'h100 + 12'(win * 12'h080) + 12'(idx * 4);
              alt = 12'h100 + 12'((1 - win) * 12'h080) + 12'(idx * 4);
              doWrite(a, proc, ns[0], d);
              modelWrite(idx, proc, ns[0], ds[0], win[0], d);
              checkOutputs(tg);
              doRead(a, proc, ns[0], expRead(idx, proc, ns[0], ds[0], 1'b0),
                     expRead(idx, proc, ns[0], ds[0], 1'b1), tg);
              doRead(alt, proc, ns[0], expRead(idx, proc, ns[0], ds[0], 1'b0),
                     expRead(idx, proc, ns[0], ds[0], 1'b1), {tg, " R3 other alias"});
            end
          end
        end
      end
    end

    // R4: banking - set all of proc 0 register 0, proc 1 copy stays put
    secDisable = 1'b1;
    doWrite(12'h180, 1, 1'b0, 32'hFFFF_FFFF); modelWrite(0, 1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    doWrite(12'h100, 0, 1'b0, 32'hFFFF_FFFF); modelWrite(0, 0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    doRead(12'h100, 0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 proc0 copy");
    doRead(12'h100, 1, 1'b0, 32'h0, 32'h0000_FFFF, "R4 proc1 copy");
    checkOutputs("R4 banked");

    // R8: clear attempt on fixed software-generated bits
    doWrite(12'h180, 0, 1'b0, 32'h0000_FFFF); modelWrite(0, 0, 1'b0, 1'b1, 1'b1, 32'h0000_FFFF);
    doRead(12'h180, 0, 1'b0, 32'hFFFF_0000, 32'hFFFF_FFFF, "R8 sgi clear");

    // R9: other windows, out-of-range index, misaligned
    doWrite(12'h080, 2, 1'b0, 32'hFFFF_FFFF);
    doWrite(12'h200, 2, 1'b0, 32'hFFFF_FFFF);
    doWrite(12'h10C, 2, 1'b0, 32'hFFFF_FFFF);
    doWrite(12'h105, 2, 1'b0, 32'hFFFF_FFFF);
    doWrite(12'h181, 0, 1'b0, 32'hFFFF_FFFF);
    checkOutputs("R9 ignored writes");
    doRead(12'h200, 2, 1'b0, 32'h0, 32'h0, "R9 outside window");
    doRead(12'h101, 0, 1'b0, 32'h0, 32'h0, "R9 misaligned");

    // R5: processor index 8 and above
    doWrite(12'h100, 9, 1'b0, 32'hFFFF_FFFF);
    checkOutputs("R5 high index");
    doRead(12'h100, 8, 1'b0, 32'h0, 32'h0, "R5 high index");

    @(negedge clk);
    check("R10 idle rdata end", 128'(rdMain), 128'(0));
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule